// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps the rename state of a floating-point register file of sixteen double registers, F0, F2, up to F30. Each register has two fields. The first is its committed value. The second is a 4-bit producer tag that names the reservation station or load buffer that will deliver the register's next value. The tag code 0 means no producer is pending. Register Fn is addressed by index n/2, so F0 is index 0 and F30 is index 15.

During issue, the core presents two source indices and reads back, for each one, either a ready value or the producer tag to wait on. In the same cycle it names a destination index and the issuing station's tag. That tag replaces whatever producer the destination had before. When a result is broadcast on the common data bus with its tag, every register still waiting on that exact tag takes the value and becomes ready. A register that was renamed again in the meantime ignores the broadcast.

Both source lookups are combinational. Their outputs are valid in the same cycle as the indices. Rename and broadcast updates take effect at the next rising clock edge.

Top module: `rename_status_table`

## Requirements
- R1: After reset, every register has tag 0 and value 0, so a lookup of any index returns tag 0 and value 0.
- R2: A lookup of a register with tag 0 returns tag 0 and the stored value. A lookup of a register with a nonzero tag returns that tag and value 0.
- R3: When issue_valid is 1, the tag of register issue_dst becomes issue_tag one cycle later. This happens even if the register already has a pending producer.
- R4: A broadcast (cdb_valid 1) whose tag equals a register's nonzero tag writes cdb_data into that register and clears its tag to 0 at the next edge.
- R5: A broadcast whose tag differs from a register's current tag leaves that register's tag and value unchanged. This covers a stale broadcast from a producer that has since been replaced.
- R6: If a register is renamed in the same cycle that a broadcast matches its old tag, the new tag is kept and the value is not written.
- R7: A lookup in the same cycle as a broadcast matching the looked-up register returns tag 0 and cdb_data.
- R8: Lookups made in an issue cycle see the state before that issue's rename. A source equal to the destination therefore returns the previous producer tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Rename issue_dst to issue_tag this cycle |
| issue_dst | input | 4 | Destination register index (Fn at n/2) |
| issue_tag | input | 4 | Tag of the issuing station, nonzero |
| src_a_idx | input | 4 | First source register index |
| src_b_idx | input | 4 | Second source register index |
| src_a_tag | output | 4 | First source producer tag, 0 when ready |
| src_a_value | output | 64 | First source value when ready, else 0 |
| src_b_tag | output | 4 | Second source producer tag, 0 when ready |
| src_b_value | output | 64 | Second source value when ready, else 0 |
| cdb_valid | input | 1 | Broadcast present this cycle |
| cdb_tag | input | 4 | Tag of the broadcasting station |
| cdb_data | input | 64 | Broadcast result value |

## Verification
The assertions assume that an issuing station never carries tag 0. A rename to tag 0 would otherwise look like a ready register holding an unwritten value. The stimulus only issues nonzero tags, and it never drives cdb_valid with tag 0, which the design treats as a broadcast that matches no register. Every input changes only on the falling clock edge, so lookups are sampled while their operands are stable.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int RST_NREG   = 16;
  localparam int RST_TAG_W  = 4;
  localparam int RST_DATA_W = 64;
  localparam int RST_PORTS  = 2;
endpackage

// File: rtl/rst_entry.sv
module rst_entry #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rename,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [TAG_W-1:0]  qi,
  output logic [DATA_W-1:0] val,
  output logic              hit
);
  function automatic logic f_match(logic v, logic [TAG_W-1:0] bt, logic [TAG_W-1:0] own);
    return v && (own != '0) && (own == bt);
  endfunction

  assign hit = f_match(cdb_valid, cdb_tag, qi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qi  <= '0;
      val <= '0;
    end else if (rename) begin
      qi <= new_tag;
    end else if (hit) begin
      qi  <= '0;
      val <= cdb_data;
    end
  end

  AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    rename |=> (qi == $past(new_tag))); // R3
  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rename) |=> (qi == '0 && val == $past(cdb_data))); // R4
  AST_STALE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !rename) |=> ($stable(qi) && $stable(val))); // R5
  AST_RENAME_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rename |=> $stable(val)); // R6
endmodule

// File: rtl/rst_src_port.sv
module rst_src_port #(
  parameter int NREG   = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            sel,
  input  logic [NREG-1:0][TAG_W-1:0]  qi_all,
  input  logic [NREG-1:0][DATA_W-1:0] val_all,
  input  logic [NREG-1:0]             hit_all,
  input  logic [DATA_W-1:0]           cdb_data,
  output logic [TAG_W-1:0]            tag_out,
  output logic [DATA_W-1:0]           value_out
);
  logic [TAG_W-1:0]  sel_qi;
  logic [DATA_W-1:0] sel_val;
  logic              sel_hit;

  assign sel_qi  = qi_all[sel];
  assign sel_val = val_all[sel];
  assign sel_hit = hit_all[sel];

  always_comb begin
    if (sel_hit) begin
      tag_out   = '0;
      value_out = cdb_data;
    end else if (sel_qi != '0) begin
      tag_out   = sel_qi;
      value_out = '0;
    end else begin
      tag_out   = '0;
      value_out = sel_val;
    end
  end

  AST_BYPASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (tag_out == '0 && value_out == cdb_data)); // R7
  AST_PENDING_NO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_out != '0) |-> (value_out == '0)); // R2
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int NREG   = RST_NREG,
  parameter int TAG_W  = RST_TAG_W,
  parameter int DATA_W = RST_DATA_W,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [IDX_W-1:0]  issue_dst,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic [DATA_W-1:0] src_a_value,
  output logic [TAG_W-1:0]  src_b_tag,
  output logic [DATA_W-1:0] src_b_value,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  logic [NREG-1:0][TAG_W-1:0]      qi_all;
  logic [NREG-1:0][DATA_W-1:0]     val_all;
  logic [NREG-1:0]                 hit_all;
  logic [NREG-1:0]                 rename_vec;
  logic [RST_PORTS-1:0][IDX_W-1:0] sel_p;
  logic [RST_PORTS-1:0][TAG_W-1:0] tag_p;
  logic [RST_PORTS-1:0][DATA_W-1:0] val_p;

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      assign rename_vec[r] = issue_valid && (issue_dst == IDX_W'(r));
      rst_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
        .clk(clk), .rst_n(rst_n),
        .rename(rename_vec[r]), .new_tag(issue_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .qi(qi_all[r]), .val(val_all[r]), .hit(hit_all[r])
      );
    end
  endgenerate

  assign sel_p[0] = src_a_idx;
  assign sel_p[1] = src_b_idx;

  genvar p;
  generate
    for (p = 0; p < RST_PORTS; p++) begin : g_port
      rst_src_port #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .sel(sel_p[p]),
        .qi_all(qi_all), .val_all(val_all), .hit_all(hit_all),
        .cdb_data(cdb_data), .tag_out(tag_p[p]), .value_out(val_p[p])
      );
    end
  endgenerate

  assign src_a_tag   = tag_p[0];
  assign src_a_value = val_p[0];
  assign src_b_tag   = tag_p[1];
  assign src_b_value = val_p[1];

  AST_ISSUE_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_tag != '0)); // R3
  AST_ONE_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rename_vec)); // R3
endmodule

// File: tb/sim_rename_status_table.sv
module sim_rename_status_table;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        issue_valid = 0;
  logic [3:0]  issue_dst = 0, issue_tag = 0, src_a_idx = 0, src_b_idx = 0;
  logic [3:0]  src_a_tag, src_b_tag;
  logic [63:0] src_a_value, src_b_value;
  logic        cdb_valid = 0;
  logic [3:0]  cdb_tag = 0;
  logic [63:0] cdb_data = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rename_status_table u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_dst(issue_dst),
    .issue_tag(issue_tag), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .src_a_tag(src_a_tag), .src_a_value(src_a_value),
    .src_b_tag(src_b_tag), .src_b_value(src_b_value),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(int idx, logic [3:0] tag, logic [63:0] v, string req);
    issue_valid = 0; cdb_valid = 0; src_a_idx = idx[3:0];
    #1;
    chk(req, {60'd0, src_a_tag}, {60'd0, tag});
    chk(req, src_a_value, v);
  endtask

  task automatic do_issue(int dst, logic [3:0] tag);
    issue_valid = 1; issue_dst = dst[3:0]; issue_tag = tag;
    step();
    issue_valid = 0;
  endtask

  task automatic bcast(logic [3:0] tag, logic [63:0] d);
    cdb_valid = 1; cdb_tag = tag; cdb_data = d;
    step();
    cdb_valid = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) look(i, 4'd0, 64'd0, "R1 reset");
  endtask

  task automatic t_basic();
    do_issue(3, 4'd5);
    look(3, 4'd5, 64'd0, "R2 R3 pending lookup");
    cdb_valid = 1; cdb_tag = 4'd5; cdb_data = 64'hA5A5_0000_1111_2222;
    src_b_idx = 4'd3;
    #1;
    chk("R7 bypass tag", {60'd0, src_b_tag}, 64'd0);
    chk("R7 bypass value", src_b_value, 64'hA5A5_0000_1111_2222);
    step();
    cdb_valid = 0;
    look(3, 4'd0, 64'hA5A5_0000_1111_2222, "R4 R2 written");
  endtask

  task automatic t_waw();
    do_issue(4, 4'd6);
    do_issue(4, 4'd7);
    look(4, 4'd7, 64'd0, "R3 rename over pending");
    bcast(4'd6, 64'hBBBB);
    look(4, 4'd7, 64'd0, "R5 stale broadcast");
    bcast(4'd7, 64'hCCCC);
    look(4, 4'd0, 64'hCCCC, "R4 final broadcast");
  endtask

  task automatic t_selective();
    do_issue(10, 4'd2);
    do_issue(11, 4'd3);
    bcast(4'd2, 64'h1234);
    look(10, 4'd0, 64'h1234, "R4 matching register");
    look(11, 4'd3, 64'd0, "R5 other register untouched");
    look(3, 4'd0, 64'hA5A5_0000_1111_2222, "R5 ready register untouched");
  endtask

  task automatic t_race();
    do_issue(12, 4'd1);
    issue_valid = 1; issue_dst = 4'd12; issue_tag = 4'd4;
    cdb_valid = 1; cdb_tag = 4'd1; cdb_data = 64'hDDDD;
    step();
    issue_valid = 0; cdb_valid = 0;
    look(12, 4'd4, 64'd0, "R6 new tag wins");
    bcast(4'd4, 64'hEEEE);
    look(12, 4'd0, 64'hEEEE, "R6 later match writes");
  endtask

  task automatic t_self_src();
    do_issue(5, 4'd8);
    issue_valid = 1; issue_dst = 4'd5; issue_tag = 4'd10;
    src_a_idx = 4'd5;
    #1;
    chk("R8 source sees old tag", {60'd0, src_a_tag}, 64'd8);
    step();
    issue_valid = 0;
    look(5, 4'd10, 64'd0, "R8 rename after read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_waw();
    t_selective();
    t_race();
    t_self_src();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule